// File: doc/BRIEF.md
# Rank Interleave Decoder

This block turns a channel-local memory address into a rank selection and an address inside that rank. Software first loads a small table through a write port. The table holds up to four rank-range words, and each range carries up to eight interleave words, one per way. A request then presents an address together with a flag that gives the channel's page policy.

The block searches the ranges in index order and takes the first valid one that covers the address. It removes the rank-interleave bits that sit just above a policy-dependent shift point and uses them to pick one of the range's interleave words. That word supplies the channel rank and an offset, and the offset is subtracted to give the rank-local address.

Every request is answered exactly one cycle later by a one-cycle done pulse. If no range matches, the done pulse carries an error flag and all results are zero.

Top module: `rank_ilv_decoder`

## Requirements
- R1: After reset, done_o and err_o are low and chan_rank_o, dimm_o, rank_o and rank_addr_o are zero. Every table word is zero, so a request made straight after reset ends in the no-match error.
- R2: Range word fields are decoded as follows:
  - bit 31 is the valid flag;
  - the range limit is bits 11:1 placed at address bits 39:29, with address bits 28:0 all ones;
  - the way count is 2 raised to the value in bits 29:28, so 1, 2, 4 or 8 ways.
- R3: Ranges are searched from index 0 upward, and the first valid range whose lower bound is at or below the address, and whose limit is at or above it, wins. Lower-bound rules:
  - range 0 has a lower bound of zero;
  - for every other range, the lower bound is the limit of the range just before it, with nothing added;
  - this lower bound is carried across invalid ranges as well, so an address equal to an earlier valid range's limit is claimed by that earlier range.
- R4: The interleave shift is 6 when close_page_i is 1 and 13 when it is 0.
- R5: With shift s and way count w:
  - the way index is (addr >> s) mod w;
  - the rank address before the offset is ((addr >> s) / w) << s, ORed with the low s bits of addr.
- R6: The interleave word is chosen by the matched range and the way index. Its bits 15:2, placed at address bits 39:26, are subtracted from the rank address modulo 2^40 to give rank_addr_o.
- R7: chan_rank_o is interleave-word bits 19:16. dimm_o is chan_rank_o / 4, and rank_o is chan_rank_o mod 4.
- R8: When no valid range matches, the done pulse carries err_o = 1 and chan_rank_o, dimm_o, rank_o and rank_addr_o are all zero.
- R9: Timing of the response:
  - a request sampled on a clock edge raises done_o for exactly the following cycle;
  - back-to-back requests each get their own pulse;
  - outputs keep their values in cycles with no response.
- R10: The write port is addressed by cfg_addr_i:
  - bit 5 = 0 writes the range word of entry bits 4:3;
  - bit 5 = 1 writes the interleave word of entry bits 4:3 and way bits 2:0.
  A write taken on the same edge as a request is not seen by that request; it is seen by every later request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_addr_i | input | 6 | Table word select (kind, entry, way) |
| cfg_wdata_i | input | 32 | Table write data |
| req_i | input | 1 | Decode request |
| close_page_i | input | 1 | 1 = closed-page policy, 0 = open-page policy |
| chan_addr_i | input | 40 | Channel-local address to decode |
| done_o | output | 1 | One-cycle response pulse |
| err_o | output | 1 | No range matched (valid with done_o) |
| chan_rank_o | output | 4 | Channel rank |
| dimm_o | output | 2 | DIMM slot |
| rank_o | output | 2 | Rank within the DIMM |
| rank_addr_o | output | 40 | Rank-local address |

## Verification
A table write and a decode request can arrive on the same edge, and the write can target the very range word or interleave word that the request resolves to. The bench provokes this on purpose by rewriting a word while a request that lands on it is presented, and it also mixes random writes with random back-to-back requests. Its reference model answers each request from the table as it stood before the edge and only then applies the write. A request that sees the new word therefore shows up as a rank or address mismatch on that same pulse.

// File: rtl/rid_pkg.sv
package rid_pkg;
  localparam int WORD_W     = 32;
  localparam int VALID_BIT  = 31;
  localparam int LIM_LO     = 1;
  localparam int LIM_HI     = 11;
  localparam int LIM_SHIFT  = 29;
  localparam int WEXP_LO    = 28;
  localparam int WEXP_W     = 2;
  localparam int OFF_LO     = 2;
  localparam int OFF_HI     = 15;
  localparam int OFF_SHIFT  = 26;
  localparam int CRANK_LO   = 16;
  localparam int CRANK_W    = 4;
  localparam int MAX_WAYS   = 1 << ((1 << WEXP_W) - 1);
  localparam int WAY_IDX_W  = $clog2(MAX_WAYS);
  localparam int LIM_W      = LIM_HI - LIM_LO + 1 + LIM_SHIFT;
  localparam int OFF_W      = OFF_HI - OFF_LO + 1 + OFF_SHIFT;

  typedef enum logic {
    CFG_RANGE = 1'b0,
    CFG_ILV   = 1'b1
  } cfg_kind_e;
endpackage

// File: rtl/rid_cfg_store.sv
module rid_cfg_store
  import rid_pkg::*;
#(
  parameter int NUM_RANGE = 4,
  localparam int ENT_W = (NUM_RANGE > 1) ? $clog2(NUM_RANGE) : 1,
  localparam int CFG_AW = 1 + ENT_W + WAY_IDX_W
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic                                         we_i,
  input  logic [CFG_AW-1:0]                            addr_i,
  input  logic [WORD_W-1:0]                            wdata_i,
  output logic [NUM_RANGE-1:0][WORD_W-1:0]             range_words_o,
  output logic [NUM_RANGE-1:0][MAX_WAYS-1:0][WORD_W-1:0] ilv_words_o
);
  logic [WAY_IDX_W-1:0] way_sel;
  logic [ENT_W-1:0]     ent_sel;
  cfg_kind_e            kind_sel;

  assign way_sel  = addr_i[WAY_IDX_W-1:0];
  assign ent_sel  = addr_i[WAY_IDX_W +: ENT_W];
  assign kind_sel = cfg_kind_e'(addr_i[CFG_AW-1]);

  for (genvar e = 0; e < NUM_RANGE; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                                   range_words_o[e] <= '0;
      else if (we_i && kind_sel == CFG_RANGE && ent_sel == ENT_W'(e)) range_words_o[e] <= wdata_i;
    end
    for (genvar w = 0; w < MAX_WAYS; w++) begin : g_way
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ilv_words_o[e][w] <= '0;
        else if (we_i && kind_sel == CFG_ILV && ent_sel == ENT_W'(e) &&
                 way_sel == WAY_IDX_W'(w))
          ilv_words_o[e][w] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/rid_range_match.sv
module rid_range_match
  import rid_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int NUM_RANGE = 4,
  localparam int ENT_W = (NUM_RANGE > 1) ? $clog2(NUM_RANGE) : 1,
  localparam int CMP_W = (ADDR_W > LIM_W) ? ADDR_W : LIM_W
) (
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [NUM_RANGE-1:0][WORD_W-1:0]  range_words_i,
  output logic                              hit_o,
  output logic [ENT_W-1:0]                  ent_o,
  output logic [WEXP_W-1:0]                 way_exp_o
);
  logic [NUM_RANGE-1:0] unused_bits;

  for (genvar e = 0; e < NUM_RANGE; e++) begin : g_unused
    assign unused_bits[e] = ^{range_words_i[e][VALID_BIT-1], range_words_i[e][WEXP_LO-1:LIM_HI+1],
                              range_words_i[e][LIM_LO-1:0]};
  end

  // first valid hit wins; lower bound is previous limit (no +1), kept through invalid entries
  always_comb begin
    logic [CMP_W-1:0] a_ext;
    logic [CMP_W-1:0] prev_lim;
    logic [CMP_W-1:0] lim;
    a_ext     = CMP_W'(addr_i);
    prev_lim  = '0;
    hit_o     = 1'b0;
    ent_o     = '0;
    way_exp_o = '0;
    for (int i = 0; i < NUM_RANGE; i++) begin
      lim = CMP_W'({range_words_i[i][LIM_HI:LIM_LO], {LIM_SHIFT{1'b1}}});
      if (!hit_o && range_words_i[i][VALID_BIT] && prev_lim <= a_ext && a_ext <= lim) begin
        hit_o     = 1'b1;
        ent_o     = ENT_W'(i);
        way_exp_o = range_words_i[i][WEXP_LO +: WEXP_W];
      end
      prev_lim = lim;
    end
  end
endmodule

// File: rtl/rid_rank_calc.sv
module rid_rank_calc
  import rid_pkg::*;
#(
  parameter int ADDR_W      = 40,
  parameter int CLOSE_SHIFT = 6,
  parameter int OPEN_SHIFT  = 13
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 close_page_i,
  input  logic [WEXP_W-1:0]    way_exp_i,
  output logic [ADDR_W-1:0]    base_addr_o,
  output logic [WAY_IDX_W-1:0] way_idx_o
);
  logic [1:0][ADDR_W-1:0]    base_v;
  logic [1:0][WAY_IDX_W-1:0] way_v;
  logic [WAY_IDX_W-1:0]      way_mask;

  // ways is a power of two: divide/mod reduce to shift/mask
  assign way_mask = (WAY_IDX_W'(1) << way_exp_i) - WAY_IDX_W'(1);

  // index 1 = closed page, index 0 = open page; constant shift per variant
  for (genvar p = 0; p < 2; p++) begin : g_pol
    localparam int SH = (p == 1) ? CLOSE_SHIFT : OPEN_SHIFT;
    localparam logic [ADDR_W-1:0] LOW_MASK = {{(ADDR_W-SH){1'b0}}, {SH{1'b1}}};
    logic [ADDR_W-1:0] q;
    assign q         = addr_i >> SH;
    assign base_v[p] = ((q >> way_exp_i) << SH) | (addr_i & LOW_MASK);
    assign way_v[p]  = q[WAY_IDX_W-1:0] & way_mask;
  end

  assign base_addr_o = base_v[close_page_i];
  assign way_idx_o   = way_v[close_page_i];
endmodule

// File: rtl/rank_ilv_decoder.sv
module rank_ilv_decoder
  import rid_pkg::*;
#(
  parameter int ADDR_W      = 40,
  parameter int NUM_RANGE   = 4,
  parameter int CLOSE_SHIFT = 6,
  parameter int OPEN_SHIFT  = 13,
  localparam int ENT_W  = (NUM_RANGE > 1) ? $clog2(NUM_RANGE) : 1,
  localparam int CFG_AW = 1 + ENT_W + WAY_IDX_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [CFG_AW-1:0]    cfg_addr_i,
  input  logic [WORD_W-1:0]    cfg_wdata_i,
  input  logic                 req_i,
  input  logic                 close_page_i,
  input  logic [ADDR_W-1:0]    chan_addr_i,
  output logic                 done_o,
  output logic                 err_o,
  output logic [CRANK_W-1:0]   chan_rank_o,
  output logic [1:0]           dimm_o,
  output logic [1:0]           rank_o,
  output logic [ADDR_W-1:0]    rank_addr_o
);
  logic [NUM_RANGE-1:0][WORD_W-1:0]               range_words;
  logic [NUM_RANGE-1:0][MAX_WAYS-1:0][WORD_W-1:0] ilv_words;
  logic                 hit;
  logic [ENT_W-1:0]     ent;
  logic [WEXP_W-1:0]    way_exp;
  logic [ADDR_W-1:0]    base_addr;
  logic [WAY_IDX_W-1:0] way_idx;
  logic [WORD_W-1:0]    ilv_word;
  logic [OFF_W-1:0]     off_full;
  logic [ADDR_W-1:0]    off;
  logic [ADDR_W-1:0]    rank_addr_d;
  logic                 unused_ilv;

  rid_cfg_store #(.NUM_RANGE(NUM_RANGE)) u_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (cfg_we_i),
    .addr_i        (cfg_addr_i),
    .wdata_i       (cfg_wdata_i),
    .range_words_o (range_words),
    .ilv_words_o   (ilv_words)
  );

  rid_range_match #(.ADDR_W(ADDR_W), .NUM_RANGE(NUM_RANGE)) u_match (
    .addr_i        (chan_addr_i),
    .range_words_i (range_words),
    .hit_o         (hit),
    .ent_o         (ent),
    .way_exp_o     (way_exp)
  );

  rid_rank_calc #(.ADDR_W(ADDR_W), .CLOSE_SHIFT(CLOSE_SHIFT), .OPEN_SHIFT(OPEN_SHIFT)) u_calc (
    .addr_i       (chan_addr_i),
    .close_page_i (close_page_i),
    .way_exp_i    (way_exp),
    .base_addr_o  (base_addr),
    .way_idx_o    (way_idx)
  );

  assign ilv_word    = ilv_words[ent][way_idx];
  assign off_full    = {ilv_word[OFF_HI:OFF_LO], {OFF_SHIFT{1'b0}}};
  assign off         = ADDR_W'(off_full);
  assign rank_addr_d = base_addr - off;
  assign unused_ilv  = ^{ilv_word[WORD_W-1:CRANK_LO+CRANK_W], ilv_word[OFF_LO-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      chan_rank_o <= '0;
      dimm_o      <= '0;
      rank_o      <= '0;
      rank_addr_o <= '0;
    end else begin
      done_o <= req_i;
      if (req_i) begin
        err_o <= !hit;
        if (hit) begin
          chan_rank_o <= ilv_word[CRANK_LO +: CRANK_W];
          dimm_o      <= ilv_word[CRANK_LO+2 +: 2];
          rank_o      <= ilv_word[CRANK_LO +: 2];
          rank_addr_o <= rank_addr_d;
        end else begin
          chan_rank_o <= '0;
          dimm_o      <= '0;
          rank_o      <= '0;
          rank_addr_o <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/rid_checker.sv
module rid_checker #(
  parameter int ADDR_W = 40,
  parameter int LOW_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [ADDR_W-1:0] chan_addr_i,
  input logic              done_o,
  input logic              err_o,
  input logic [3:0]        chan_rank_o,
  input logic [1:0]        dimm_o,
  input logic [1:0]        rank_o,
  input logic [ADDR_W-1:0] rank_addr_o
);
  assert_req_gives_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> done_o);

  assert_idle_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !done_o && $stable(rank_addr_o) && $stable(chan_rank_o) && $stable(err_o));

  assert_err_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_o |-> chan_rank_o == '0 && dimm_o == '0 && rank_o == '0 && rank_addr_o == '0);

  assert_slot_split_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dimm_o == chan_rank_o[3:2] && rank_o == chan_rank_o[1:0]);

  // offset is a multiple of 2^26, so the low shift bits pass through
  assert_low_bits_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !err_o |-> rank_addr_o[LOW_W-1:0] == $past(chan_addr_i[LOW_W-1:0]));
endmodule

bind rank_ilv_decoder rid_checker #(.ADDR_W(ADDR_W), .LOW_W(CLOSE_SHIFT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .chan_addr_i (chan_addr_i),
  .done_o      (done_o),
  .err_o       (err_o),
  .chan_rank_o (chan_rank_o),
  .dimm_o      (dimm_o),
  .rank_o      (rank_o),
  .rank_addr_o (rank_addr_o)
);

// File: tb/rank_ilv_decoder_tb.sv
`timescale 1ns/1ps
module rank_ilv_decoder_tb;
  localparam longint unsigned AMASK = (64'h1 << 40) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req = 1'b0;
  logic        cp = 1'b0;
  logic [39:0] addr = '0;
  logic        done, err;
  logic [3:0]  crank;
  logic [1:0]  dimm, rnk;
  logic [39:0] raddr;

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference model state
  logic [31:0]     m_rw [4];
  logic [31:0]     m_iw [4][8];
  bit              e_done = 0, e_err = 0;
  int              e_cr = 0;
  longint unsigned e_ra = 0;

  always #4 clk = ~clk;

  rank_ilv_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .req_i(req), .close_page_i(cp), .chan_addr_i(addr),
    .done_o(done), .err_o(err), .chan_rank_o(crank), .dimm_o(dimm), .rank_o(rnk),
    .rank_addr_o(raddr)
  );

  function automatic void ref_decode(input longint unsigned a, input bit cpol,
                                     output bit er, output int cr, output longint unsigned ra);
    longint unsigned prev = 0, lim, q, w, sh, base, off;
    int hit = -1, idx;
    for (int i = 0; i < 4; i++) begin
      lim = ((longint'(m_rw[i] >> 1) & 64'h7FF) << 29) | 64'h1FFF_FFFF;
      if (hit < 0 && m_rw[i][31] && prev <= a && a <= lim) hit = i;
      prev = lim;
    end
    if (hit < 0) begin er = 1; cr = 0; ra = 0; return; end
    sh   = cpol ? 6 : 13;
    w    = 64'h1 << ((m_rw[hit] >> 28) & 3);
    q    = a >> sh;
    idx  = int'(q % w);
    base = ((q / w) << sh) | (a & ((64'h1 << sh) - 1));
    off  = (longint'(m_iw[hit][idx] >> 2) & 64'h3FFF) << 26;
    er   = 0;
    cr   = int'((m_iw[hit][idx] >> 16) & 15);
    ra   = (base - off) & AMASK;
  endfunction

  task automatic chk(input string tag, input string fld, input longint unsigned act,
                     input longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, fld, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    bit er; int cr; longint unsigned ra;
    @(posedge clk);
    if (req) begin
      ref_decode(longint'(addr), cp, er, cr, ra);
      e_done = 1; e_err = er; e_cr = cr; e_ra = ra;
    end else e_done = 0;
    if (cfg_we) begin
      if (cfg_addr[5]) m_iw[cfg_addr[4:3]][cfg_addr[2:0]] = cfg_wdata;
      else             m_rw[cfg_addr[4:3]] = cfg_wdata;
    end
    #2;
    chk(tag, "done R9", longint'(done), longint'(e_done));
    chk(tag, "err R8", longint'(err), longint'(e_err));
    chk(tag, "chan_rank R7", longint'(crank), longint'(e_cr));
    chk(tag, "dimm R7", longint'(dimm), longint'(e_cr / 4));
    chk(tag, "rank R7", longint'(rnk), longint'(e_cr % 4));
    chk(tag, "rank_addr R6", longint'(raddr), e_ra);
  endtask

  task automatic wr(input bit ilv, input int ent, input int way, input logic [31:0] d,
                    input string tag);
    cfg_we = 1; cfg_addr = {ilv, 2'(ent), 3'(way)}; cfg_wdata = d;
    tick(tag);
    cfg_we = 0;
  endtask

  task automatic rq(input longint unsigned a, input bit cpol, input string tag);
    req = 1; addr = 40'(a); cp = cpol;
    tick(tag);
    req = 0;
  endtask

  function automatic logic [31:0] rword(input bit v, input int wexp, input int lf);
    return {v, 1'b0, 2'(wexp), 16'h0, 11'(lf), 1'b0};
  endfunction

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_rw[i] = '0;
      for (int j = 0; j < 8; j++) m_iw[i][j] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1", "done", longint'(done), 0);
    chk("R1", "rank_addr", longint'(raddr), 0);
    chk("R1", "chan_rank", longint'(crank), 0);
    rq(40'h12345, 1, "R1");               // empty table -> error
    tick("R9");

    // table: e0 1 way limit 0x3FFFFFFF, e1 invalid 0x7FFFFFFF, e2 4 ways 0xFFFFFFFF, e3 8 ways max
    wr(0, 0, 0, rword(1, 0, 1), "R10");
    wr(0, 1, 0, rword(0, 1, 3), "R10");
    wr(0, 2, 0, rword(1, 2, 7), "R10");
    wr(0, 3, 0, rword(1, 3, 11'h7FF), "R10");
    for (int e = 0; e < 4; e++)
      for (int w = 0; w < 8; w++)
        wr(1, e, w, {12'h0, 4'((e * 4 + w) & 15), 2'b0, 14'(e), 2'b0}, "R10");

    rq(64'h0, 1, "R2");
    rq(64'h3FFF_FFFF, 0, "R3");            // top of e0
    rq(64'h4000_0000, 1, "R3");            // inside invalid e1, below e2 lower bound -> error
    rq(64'h7FFF_FFFF, 1, "R3");            // equals e1 limit, e2 inclusive lower bound
    rq(64'h8000_12C0, 1, "R4");
    rq(64'h8000_12C0, 0, "R4");
    rq(64'hFFFF_FFFF, 0, "R3");            // both e2 and e3 cover it, e2 wins
    rq(64'h1_0000_4040, 1, "R5");
    rq(64'hFF_FFFF_FFFF, 0, "R5");
    tick("R9");
    rq(64'h1234_5678, 1, "R9");
    rq(64'h9876_5432, 0, "R9");           // back-to-back
    tick("R9"); tick("R9");

    // large offset on e0 wraps below zero
    wr(1, 0, 0, {12'h0, 4'hB, 2'b0, 14'h3FFF, 2'b0}, "R6");
    rq(64'h40, 1, "R6");

    // same-edge write versus request on the word it resolves to
    cfg_we = 1; cfg_addr = {1'b1, 2'd0, 3'd0}; cfg_wdata = {12'h0, 4'h5, 2'b0, 14'h1, 2'b0};
    rq(64'h80, 1, "R10");
    cfg_we = 0;
    rq(64'h80, 1, "R10");
    cfg_we = 1; cfg_addr = {1'b0, 2'd0, 3'd0}; cfg_wdata = rword(0, 0, 1);
    rq(64'h100, 0, "R10");                // old e0 still valid for this request
    cfg_we = 0;
    rq(64'h100, 0, "R10");                // now error

    // shrink e3 so high addresses miss
    wr(0, 3, 0, rword(1, 1, 16), "R2");
    rq(64'h2_1FFF_FFFF, 1, "R2");
    rq(64'h3_0000_0000, 1, "R8");

    for (int n = 0; n < 3000; n++) begin
      longint unsigned a;
      a = {$urandom, $urandom} & AMASK;
      if (($urandom % 4) == 0) a = a & 64'h3_FFFF_FFFF;
      if (($urandom % 5) == 0) begin
        cfg_we = 1;
        if (($urandom % 6) == 0)
          cfg_wdata = rword(($urandom % 8) != 0, int'($urandom % 4), int'($urandom % 2048));
        else cfg_wdata = $urandom;
        cfg_addr = 6'($urandom);
        if (cfg_addr[5] == 0) cfg_wdata[31] = cfg_wdata[31] | (($urandom % 8) != 0);
      end
      req = ($urandom % 10) < 7;
      addr = 40'(a);
      cp = 1'($urandom);
      tick("R5");
      cfg_we = 0; req = 0;
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R9 watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule